// File: doc/BRIEF.md
# Per-Channel Receive Code Insertion

This block sits in the receive datapath of a 24-timeslot T1 framer, downstream of frame alignment. It takes the serial receive stream one bit per strobe, together with a frame-sync pulse that marks the framing bit. It forwards the stream bit for bit, except that any timeslot whose enable bit is set is overwritten with a programmed 8-bit code. Each channel has its own code byte, sent MSB first. The framing bit always passes through untouched.

A simple write-only register port loads the enable mask and the 24 code bytes. The enable mask is held in three byte-wide registers. The code bytes sit in 24 consecutive registers. The choice of byte and the enable flag are sampled only on the first bit of each channel, so a write that lands mid-channel never leaves a byte partly replaced.

A small position tracker follows the frame. Its states are ST_HUNT (no sync seen since reset), ST_CHAN (inside the 192 channel bits) and ST_FBIT_DUE (channel bits finished, waiting for the next framing bit). Its transitions are:
- `SYNC`: a strobe with frame-sync, taken from any state into ST_CHAN at channel 1, bit 0.
- `ADVANCE`: a channel-bit strobe, which stays in ST_CHAN.
- `FRAME_END`: the last bit of channel 24, from ST_CHAN to ST_FBIT_DUE.
- `IDLE`: a strobe without frame-sync in ST_HUNT or ST_FBIT_DUE, which keeps the current state.

Top module: `rx_code_insert`

## Requirements
- R1: After reset `rx_data_out` is 0 and every enable bit is 0, so the block passes data through until it is programmed.
- R2: A strobe with `rx_fsync` high is the framing bit. It is output unchanged and places the next strobe at channel 1, bit 0.
- R3: A channel whose enable bit is 0 outputs the received bits unchanged.
- R4: A channel whose enable bit is 1 outputs its code byte in place of the received bits. Bit 7 of the code goes out on the first bit time of the channel and bit 0 on the eighth.
- R5: The enable for channel n (1..24) is bit (n-1) mod 8 of the register at address 0x1B + (n-1) div 8. Channel 1 is bit 0 at 0x1B and channel 24 is bit 7 at 0x1D.
- R6: The code byte for channel n (1..24) is written at address 0x20 + n - 1.
- R7: The enable bit and code byte of a channel are sampled on its first bit strobe. A write made while a channel is in progress first affects the next occurrence of that channel.
- R8: `rx_data_out` changes only at the clock edge that takes a strobe, showing that strobe's result from the next cycle on. It holds between strobes.
- R9: After the 192nd channel bit, strobes without frame-sync pass through unchanged until a framing bit arrives. Strobes before the first frame-sync after reset also pass through.
- R10: A frame-sync strobe in the middle of a frame restarts the position count at channel 1, bit 0.
- R11: Writes to any address other than 0x1B..0x1D and 0x20..0x37 change no enable bit and no code byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register write address |
| cfg_wdata | input | 8 | Register write data |
| rx_bit_en | input | 1 | One-cycle strobe per received bit |
| rx_fsync | input | 1 | Marks the strobe that carries the framing bit |
| rx_data | input | 1 | Received serial bit, valid with the strobe |
| rx_data_out | output | 1 | Serial output with enabled channels overwritten |

## Verification
The assertions rely on three input conditions. `rx_fsync` is only meaningful together with `rx_bit_en`. Data is presented with its strobe. The channel count divides into whole 8-bit registers. The bench drives every bit as a one-cycle strobe followed by an idle cycle, and always raises frame-sync together with a strobe. It makes register writes only in the idle cycles between strobes, including writes partway through a channel. The gaps between strobes let the bench check that the output holds, and let it compare each strobe's result one cycle after the strobe.

// File: rtl/rci_pkg.sv
package rci_pkg;
    typedef enum logic [1:0] {
        ST_HUNT     = 2'd0,
        ST_CHAN     = 2'd1,
        ST_FBIT_DUE = 2'd2
    } pos_state_t;
endpackage

// File: rtl/rci_reg_bank.sv
module rci_reg_bank #(
    parameter int NUM_CH    = 24,
    parameter int CODE_W    = 8,
    parameter int ADDR_W    = 8,
    parameter int EN_BASE   = 'h1B,
    parameter int CODE_BASE = 'h20
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [CODE_W-1:0]              wr_data,
    output logic [NUM_CH-1:0]              en_mask,
    output logic [NUM_CH-1:0][CODE_W-1:0]  codes
);
    localparam int EN_REGS = NUM_CH / CODE_W;

    for (genvar g = 0; g < EN_REGS; g++) begin : g_en
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(EN_BASE + g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                en_mask[g*CODE_W +: CODE_W] <= '0;
            else if (wr_en && wr_addr == MY_ADDR)
                en_mask[g*CODE_W +: CODE_W] <= wr_data;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_code
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(CODE_BASE + c);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                codes[c] <= '0;
            else if (wr_en && wr_addr == MY_ADDR)
                codes[c] <= wr_data;
        end
    end

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(en_mask)); // R11
    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(codes)); // R11
endmodule

// File: rtl/rci_frame_fsm.sv
module rci_frame_fsm
    import rci_pkg::*;
#(
    parameter int NUM_CH = 24,
    parameter int CODE_W = 8,
    localparam int CH_W  = $clog2(NUM_CH),
    localparam int BIT_W = $clog2(CODE_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             fsync,
    output logic             in_chan,
    output logic             first_bit,
    output logic [CH_W-1:0]  chan_idx
);
    pos_state_t        state_q, state_n;
    logic [CH_W-1:0]   chan_q, chan_n;
    logic [BIT_W-1:0]  bit_q, bit_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            chan_q  <= '0;
            bit_q   <= '0;
        end else begin
            state_q <= state_n;
            chan_q  <= chan_n;
            bit_q   <= bit_n;
        end
    end

    // transitions and outputs
    always_comb begin
        state_n   = state_q;
        chan_n    = chan_q;
        bit_n     = bit_q;
        in_chan   = (state_q == ST_CHAN) && !fsync;
        first_bit = in_chan && (bit_q == '0);
        chan_idx  = chan_q;
        if (bit_en) begin
            if (fsync) begin
                state_n = ST_CHAN;       // SYNC
                chan_n  = '0;
                bit_n   = '0;
            end else begin
                unique case (state_q)
                    ST_HUNT, ST_FBIT_DUE: state_n = state_q;  // IDLE
                    ST_CHAN: begin
                        if (bit_q == BIT_W'(CODE_W - 1)) begin
                            bit_n = '0;
                            if (chan_q == CH_W'(NUM_CH - 1)) begin
                                state_n = ST_FBIT_DUE;    // FRAME_END
                                chan_n  = '0;
                            end else begin
                                chan_n  = chan_q + 1'b1;  // ADVANCE
                            end
                        end else begin
                            bit_n = bit_q + 1'b1;         // ADVANCE
                        end
                    end
                    default: state_n = ST_HUNT;
                endcase
            end
        end
    end

    AST_CHAN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        chan_q < CH_W'(NUM_CH)); // R5
    AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en && fsync |=> state_q == ST_CHAN && chan_q == '0 && bit_q == '0); // R10
    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_FBIT_DUE && !(bit_en && fsync) |=> state_q == ST_FBIT_DUE); // R9
endmodule

// File: rtl/rci_bit_mux.sv
module rci_bit_mux #(
    parameter int NUM_CH = 24,
    parameter int CODE_W = 8,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bit_en,
    input  logic                           rx_data,
    input  logic                           in_chan,
    input  logic                           first_bit,
    input  logic [CH_W-1:0]                chan_idx,
    input  logic [NUM_CH-1:0]              en_mask,
    input  logic [NUM_CH-1:0][CODE_W-1:0]  codes,
    output logic                           dout
);
    logic              cur_en;
    logic [CODE_W-1:0] cur_byte;
    logic              sel_en;
    logic [CODE_W-1:0] sel_byte;
    logic              nxt_bit;

    always_comb begin
        sel_en   = en_mask[chan_idx];
        sel_byte = codes[chan_idx];
        nxt_bit  = rx_data;
        if (first_bit)
            nxt_bit = sel_en ? sel_byte[CODE_W-1] : rx_data;
        else if (in_chan)
            nxt_bit = cur_en ? cur_byte[CODE_W-1] : rx_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout     <= 1'b0;
            cur_en   <= 1'b0;
            cur_byte <= '0;
        end else if (bit_en) begin
            dout <= nxt_bit;
            if (first_bit) begin
                cur_en   <= sel_en;
                cur_byte <= {sel_byte[CODE_W-2:0], 1'b0};
            end else if (in_chan) begin
                cur_byte <= {cur_byte[CODE_W-2:0], 1'b0};
            end
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(dout)); // R8
    AST_PASS_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en && !in_chan |=> dout == $past(rx_data)); // R2
    AST_PASS_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en && first_bit && !sel_en |=> dout == $past(rx_data)); // R3
    AST_INSERT_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en && first_bit && sel_en |=> dout == $past(sel_byte[CODE_W-1])); // R4
    AST_BYTE_ATOMIC: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_en && first_bit) |=> $stable(cur_en)); // R7
endmodule

// File: rtl/rx_code_insert.sv
module rx_code_insert #(
    parameter int NUM_CH    = 24,
    parameter int CODE_W    = 8,
    parameter int ADDR_W    = 8,
    parameter int EN_BASE   = 'h1B,
    parameter int CODE_BASE = 'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CODE_W-1:0] cfg_wdata,
    input  logic              rx_bit_en,
    input  logic              rx_fsync,
    input  logic              rx_data,
    output logic              rx_data_out
);
    localparam int CH_W = $clog2(NUM_CH);

    logic [NUM_CH-1:0]             en_mask;
    logic [NUM_CH-1:0][CODE_W-1:0] codes;
    logic                          in_chan;
    logic                          first_bit;
    logic [CH_W-1:0]               chan_idx;

    rci_reg_bank #(
        .NUM_CH(NUM_CH), .CODE_W(CODE_W), .ADDR_W(ADDR_W),
        .EN_BASE(EN_BASE), .CODE_BASE(CODE_BASE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_wr_en), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
        .en_mask(en_mask), .codes(codes)
    );

    rci_frame_fsm #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .bit_en(rx_bit_en), .fsync(rx_fsync),
        .in_chan(in_chan), .first_bit(first_bit), .chan_idx(chan_idx)
    );

    rci_bit_mux #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_mux (
        .clk(clk), .rst_n(rst_n),
        .bit_en(rx_bit_en), .rx_data(rx_data),
        .in_chan(in_chan), .first_bit(first_bit), .chan_idx(chan_idx),
        .en_mask(en_mask), .codes(codes),
        .dout(rx_data_out)
    );
endmodule

// File: tb/rx_code_insert_tb.sv
module rx_code_insert_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr_en = 1'b0;
    logic [7:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       rx_bit_en = 1'b0;
    logic       rx_fsync = 1'b0;
    logic       rx_data = 1'b0;
    logic       rx_data_out;

    always #2.5 clk = ~clk;  // 200 MHz

    rx_code_insert dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .rx_bit_en(rx_bit_en), .rx_fsync(rx_fsync), .rx_data(rx_data),
        .rx_data_out(rx_data_out)
    );

    typedef struct { logic exp; string tag; } item_t;
    item_t q[$];

    int   n_cmp = 0, n_bad = 0;
    bit   mon_on = 0, done = 0;
    logic strobe_q = 1'b0;
    logic last_out = 1'b0;
    string phase = "R1";

    // reference model built from the requirements
    logic [23:0]    m_en = '0;
    logic [7:0]     m_code [24];
    int             pos = -1;
    logic           l_en = 1'b0;
    logic [7:0]     l_code = '0;
    logic [15:0]    lfsr = 16'hACE1;

    task automatic check(input logic act, input logic exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: rx_data_out=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
        if (a >= 8'h1B && a <= 8'h1D) m_en[(a - 8'h1B)*8 +: 8] = d;      // R5
        else if (a >= 8'h20 && a <= 8'h37) m_code[a - 8'h20] = d;        // R6
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic send_bit(input logic d, input logic fs);
        item_t it;
        string kind;
        logic e;
        if (fs) begin
            e = d; kind = "R2"; pos = 0;
        end else if (pos < 0) begin
            e = d; kind = "R9";
        end else begin
            int ch = pos / 8;
            int b  = pos % 8;
            if (b == 0) begin l_en = m_en[ch]; l_code = m_code[ch]; end  // R7
            e = l_en ? l_code[7-b] : d;
            kind = l_en ? "R4" : "R3";
            pos++;
            if (pos == 192) pos = -1;
        end
        it.exp = e; it.tag = {phase, "/", kind};
        @(negedge clk);
        rx_bit_en = 1'b1; rx_fsync = fs; rx_data = d;
        q.push_back(it);
        @(negedge clk);
        rx_bit_en = 1'b0; rx_fsync = 1'b0; rx_data = 1'b0;
    endtask

    function automatic logic next_rand();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    task automatic send_bits(input int n);
        for (int i = 0; i < n; i++) send_bit(next_rand(), 1'b0);
    endtask

    task automatic send_frame();
        send_bit(next_rand(), 1'b1);
        send_bits(192);
    endtask

    // monitor
    always @(posedge clk) strobe_q <= rx_bit_en;

    always @(negedge clk) begin
        if (mon_on) begin
            if (strobe_q) begin
                if (q.size() == 0) begin
                    n_cmp++; n_bad++;
                    $display("FAIL R8: output event with empty queue, actual=%b expected=none", rx_data_out);
                end else begin
                    item_t it;
                    it = q.pop_front();
                    check(rx_data_out, it.exp, it.tag);
                end
            end else begin
                check(rx_data_out, last_out, "R8/hold");
            end
            last_out = rx_data_out;
        end
    end

    initial begin
        for (int i = 0; i < 24; i++) m_code[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rx_data_out, 1'b0, "R1/reset");
        last_out = rx_data_out;
        mon_on = 1;

        phase = "R9"; send_bits(20);                 // before any sync
        phase = "R1"; send_frame();                  // transparent after reset

        phase = "R5";
        cfg_write(8'h20, 8'hA5);                     // ch1
        cfg_write(8'h27, 8'h3C);                     // ch8
        cfg_write(8'h28, 8'hC3);                     // ch9
        cfg_write(8'h37, 8'h5A);                     // ch24
        cfg_write(8'h2F, 8'hFF);                     // ch16 code, left disabled
        cfg_write(8'h1B, 8'h81);                     // ch1, ch8
        cfg_write(8'h1C, 8'h01);                     // ch9
        cfg_write(8'h1D, 8'h80);                     // ch24
        send_frame(); send_frame();

        phase = "R6";
        for (int c = 0; c < 24; c++) cfg_write(8'(8'h20 + c), 8'(c * 37 + 11));
        cfg_write(8'h1B, 8'hFF); cfg_write(8'h1C, 8'h55); cfg_write(8'h1D, 8'hAA);
        send_frame();

        phase = "R11";
        cfg_write(8'h1E, 8'h00); cfg_write(8'h1A, 8'h00);
        cfg_write(8'h1F, 8'h00); cfg_write(8'h38, 8'h00); cfg_write(8'hFF, 8'h00);
        send_frame();

        phase = "R7";
        send_bit(next_rand(), 1'b1);
        send_bits(3);                                 // into ch1
        cfg_write(8'h20, 8'h0F);                      // ch1 code changed mid-byte
        cfg_write(8'h1B, 8'hFC);                      // ch1, ch2 disabled mid ch1
        send_bits(189);
        send_frame();

        phase = "R9"; send_bits(40);                  // after frame end, no sync
        phase = "R10";
        send_bit(next_rand(), 1'b1); send_bits(77);
        send_frame();                                 // sync mid-frame restarts
        send_bits(5);

        repeat (4) @(negedge clk);
        if (q.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R8: %0d results never produced, actual=%0d expected=0", q.size(), q.size());
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL R8: watchdog expired, actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule